// File: doc/BRIEF.md
# Serial/Parallel FIFO Buffer with Seven Occupancy Flags

This block is a single-clock first-in first-out store for 9-bit words. Both sides can work in one of two ways. The write side accepts either whole words on a parallel port or a bit stream on a serial input. The read side delivers either whole words on a parallel port or a bit stream on a serial output. One mode input per side picks the style, which gives four transfer combinations: serial in with parallel out, parallel in with serial out, serial on both sides, and parallel on both sides. The serial word length is set at run time and can be from 4 to 9 bits. The upper bits of a word built from a shorter serial word are filled with zeros.

Seven flags report occupancy: empty, exactly one word, at or below one eighth, above half, at or above seven eighths, one short of full, and full. An output enable forces the parallel read data to zero without touching the FIFO contents. A write into a full store or a read from an empty one is dropped and reported by a one-cycle pulse. All strobes are sampled as clock enables on the rising edge.

Top module: `spfifo`

## Requirements
- R1: With `in_ser`=0, a high `wr_en` at a clock edge stores `wr_data`. With `out_ser`=0, a high `rd_en` at an edge removes the oldest word and shows it on `rd_data` after that edge. `rd_data` then holds it until the next read. Words come out in the order they were written.
- R2: A parallel write and a parallel read in the same cycle leave the occupancy unchanged and keep the word order. A read from an empty store still lets the write through, and a write to a full store still lets the read through.
- R3: With `in_ser`=1, each `si_en` pulse shifts in `si_bit`, least significant bit first. After L bits the word is stored with bits L and above set to zero. L is `ser_len` limited to the range 4 to 9, so 2 acts as 4. While `in_ser`=1, `wr_en` is ignored.
- R4: With `out_ser`=1 and the store not empty, a word is loaded into the serial output register, and the load counts as a read. `so_valid` is then high and `so_bit` shows bit 0. Each `so_en` moves on to the next bit. `so_last` is high while the final bit of the L-bit word is shown.
- R5: `full` is high when the occupancy equals DEPTH, and `full_m1` is high when it equals DEPTH-1.
- R6: `empty` is high at occupancy 0, and `empty_p1` is high at occupancy 1.
- R7: `afull` is high when the occupancy is at least DEPTH-DEPTH/8, and `aempty` is high when it is at most DEPTH/8.
- R8: `half` is high when the occupancy is above DEPTH/2.
- R9: A parallel write, or a completed serial word, arriving while full is discarded. `ovf` pulses high for one cycle and the occupancy stays the same.
- R10: A parallel read while empty, or an `so_en` while no serial word is loaded, is ignored. `udf` pulses high for one cycle and the occupancy stays the same.
- R11: While `oe` is low, `rd_data` is all zeros. The stored words and the flags are not changed, and raising `oe` again shows the last word read.
- R12: After reset the store is empty. Of the flags, only `empty` and `aempty` are high, and `rd_data`, `so_valid`, `ovf` and `udf` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_ser | input | 1 | Write-side mode: 1 serial, 0 parallel |
| out_ser | input | 1 | Read-side mode: 1 serial, 0 parallel |
| ser_len | input | 4 | Serial word length, limited to 4..9 |
| wr_en | input | 1 | Parallel write strobe |
| wr_data | input | 9 | Parallel write word |
| si_en | input | 1 | Serial input bit strobe |
| si_bit | input | 1 | Serial input bit |
| rd_en | input | 1 | Parallel read strobe |
| oe | input | 1 | Output enable for rd_data |
| rd_data | output | 9 | Parallel read word, zero when oe is low |
| so_en | input | 1 | Serial output advance strobe |
| so_bit | output | 1 | Current serial output bit |
| so_valid | output | 1 | A serial word is loaded |
| so_last | output | 1 | Final bit of the serial word is shown |
| full | output | 1 | Occupancy equals DEPTH |
| full_m1 | output | 1 | Occupancy equals DEPTH-1 |
| afull | output | 1 | Occupancy at least 7/8 of DEPTH |
| half | output | 1 | Occupancy above half of DEPTH |
| aempty | output | 1 | Occupancy at most 1/8 of DEPTH |
| empty_p1 | output | 1 | Occupancy equals 1 |
| empty | output | 1 | Occupancy equals 0 |
| ovf | output | 1 | Write dropped because the store was full |
| udf | output | 1 | Read dropped because no data was available |

## Verification
Directed parallel writes fill the store one word at a time and then empty it. After each step all seven flags are compared with a model. This shows whether each threshold switches at its exact occupancy, and whether a flag is off by one at the seven-eighths, half and one-eighth levels. Writes while full, reads while empty, and same-cycle read-and-write at both extremes show whether dropped requests leave the pointers alone. Serial words of lengths 4, 7, 9, and a length of 2 that must act as 4, read back in parallel or serially, check bit order, zero filling of the upper bits, the range limit and the final-bit marker. A long constrained-random mix of all four transfer styles checks word order and flags as the modes keep changing.

// File: rtl/spfifo.sv
module spfifo #(
  parameter int DEPTH = 2048,
  parameter int DW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_ser,
  input  logic          out_ser,
  input  logic [3:0]    ser_len,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          si_en,
  input  logic          si_bit,
  input  logic          rd_en,
  input  logic          oe,
  output logic [DW-1:0] rd_data,
  input  logic          so_en,
  output logic          so_bit,
  output logic          so_valid,
  output logic          so_last,
  output logic          full,
  output logic          full_m1,
  output logic          afull,
  output logic          half,
  output logic          aempty,
  output logic          empty_p1,
  output logic          empty,
  output logic          ovf,
  output logic          udf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_FM1  = CW'(DEPTH - 1);
  localparam logic [CW-1:0] LVL_AF   = CW'(DEPTH - DEPTH / 8);
  localparam logic [CW-1:0] LVL_HF   = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL_AE   = CW'(DEPTH / 8);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [3:0]    len, icnt, ocnt;
  logic [DW-1:0] isr, osr, rq, iword;
  logic          oload;

  assign len = (ser_len < 4'd4) ? 4'd4 : (ser_len > 4'(DW)) ? 4'(DW) : ser_len;

  wire ilast = (icnt == len - 4'd1);
  assign iword = isr | (DW'(si_bit) << icnt);

  wire          push_req = in_ser ? (si_en && ilast) : wr_en;
  wire [DW-1:0] push_d   = in_ser ? iword : wr_data;
  wire          pop_req  = out_ser ? !oload : rd_en;
  wire          push     = push_req && !full;
  wire          pop      = pop_req && !empty;

  assign full     = (cnt == LVL_FULL);
  assign full_m1  = (cnt == LVL_FM1);
  assign afull    = (cnt >= LVL_AF);
  assign half     = (cnt >  LVL_HF);
  assign aempty   = (cnt <= LVL_AE);
  assign empty_p1 = (cnt == CW'(1));
  assign empty    = (cnt == '0);

  assign rd_data  = oe ? rq : '0;
  assign so_bit   = osr[ocnt];
  assign so_valid = oload;
  assign so_last  = oload && (ocnt == len - 4'd1);

  always_ff @(posedge clk)
    if (push) mem[wp] <= push_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      icnt  <= '0;
      ocnt  <= '0;
      isr   <= '0;
      osr   <= '0;
      rq    <= '0;
      oload <= 1'b0;
      ovf   <= 1'b0;
      udf   <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase

      if (in_ser && si_en) begin
        if (ilast) begin
          icnt <= '0;
          isr  <= '0;
        end else begin
          icnt <= icnt + 1'b1;
          isr  <= iword;
        end
      end

      if (pop && !out_ser) rq <= mem[rp];

      if (pop && out_ser) begin
        osr   <= mem[rp];
        oload <= 1'b1;
        ocnt  <= '0;
      end else if (out_ser && oload && so_en) begin
        if (so_last) oload <= 1'b0;
        ocnt <= ocnt + 1'b1;
      end

      ovf <= push_req && full;
      udf <= out_ser ? (so_en && !oload) : (rd_en && empty);
    end
  end
endmodule

module spfifo_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ser,
  input logic          out_ser,
  input logic          wr_en,
  input logic          rd_en,
  input logic          si_en,
  input logic          full,
  input logic          full_m1,
  input logic          afull,
  input logic          half,
  input logic          aempty,
  input logic          empty_p1,
  input logic          empty,
  input logic          so_valid,
  input logic          so_last,
  input logic [CW-1:0] cnt
);
  // R5
  full_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (afull && half && !full_m1 && !empty));
  // R6
  empty_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (aempty && !empty_p1 && !half));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt))));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !in_ser && wr_en && !out_ser && !rd_en) |=> full);
  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !out_ser && rd_en && (in_ser ? !si_en : !wr_en)) |=> empty);
  // R4
  last_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_last |-> so_valid);
  // R5
  edge_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, full_m1, empty_p1, empty}));
endmodule

bind spfifo spfifo_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ser(in_ser), .out_ser(out_ser),
  .wr_en(wr_en), .rd_en(rd_en), .si_en(si_en),
  .full(full), .full_m1(full_m1), .afull(afull), .half(half),
  .aempty(aempty), .empty_p1(empty_p1), .empty(empty),
  .so_valid(so_valid), .so_last(so_last), .cnt(cnt)
);

// File: tb/spfifo_bench.sv
module spfifo_bench;
  localparam int D = 64;
  logic clk = 0, rst_n = 0;
  logic in_ser = 0, out_ser = 0, wr_en = 0, si_en = 0, si_bit = 0;
  logic rd_en = 0, oe = 1, so_en = 0;
  logic [3:0] ser_len = 4'd9;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic so_bit, so_valid, so_last, full, full_m1, afull, half, aempty, empty_p1, empty, ovf, udf;

  spfifo #(.DEPTH(D)) u_spfifo (.*);

  always #2 clk = ~clk;

  int q[$];
  int checks = 0, errors = 0;
  int last_rd = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_flags(int n);
    return {n == D, n == D - 1, n >= D - D / 8, n > D / 2, n <= D / 8, n == 1, n == 0};
  endfunction

  task automatic check_flags(string req);
    logic [6:0] a;
    a = {full, full_m1, afull, half, aempty, empty_p1, empty};
    chk(a == exp_flags(q.size()), req, int'(a), int'(exp_flags(q.size())));
  endtask

  task automatic par_write(int d);
    bit wasfull;
    wasfull = (q.size() == D);
    wr_en = 1; wr_data = 9'(d);
    @(negedge clk);
    wr_en = 0;
    if (!wasfull) q.push_back(d & 9'h1ff);
    chk(ovf == wasfull, "R9 ovf on parallel write", int'(ovf), int'(wasfull));
    check_flags("R5 R6 R7 R8 flags after write");
  endtask

  task automatic par_read();
    bit wasempty;
    wasempty = (q.size() == 0);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    if (!wasempty) last_rd = q.pop_front();
    chk(rd_data == 9'(last_rd), "R1 rd_data order", int'(rd_data), last_rd);
    chk(udf == wasempty, "R10 udf on parallel read", int'(udf), int'(wasempty));
    check_flags("R5 R6 R7 R8 flags after read");
  endtask

  task automatic par_both(int d);
    bit wasfull, wasempty;
    wasfull = (q.size() == D);
    wasempty = (q.size() == 0);
    wr_en = 1; rd_en = 1; wr_data = 9'(d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    if (!wasempty) last_rd = q.pop_front();
    if (!wasfull) q.push_back(d & 9'h1ff);
    chk(rd_data == 9'(last_rd), "R2 rd_data in same-cycle op", int'(rd_data), last_rd);
    chk(ovf == wasfull && udf == wasempty, "R2 drop pulses", int'({ovf, udf}), int'({wasfull, wasempty}));
    check_flags("R2 flags after same-cycle op");
  endtask

  task automatic ser_write(int w, int setlen);
    int l;
    bit wasfull;
    l = setlen < 4 ? 4 : (setlen > 9 ? 9 : setlen);
    wasfull = (q.size() == D);
    in_ser = 1; ser_len = 4'(setlen);
    for (int i = 0; i < l; i++) begin
      si_en = 1; si_bit = w[i];
      wr_en = 1; wr_data = 9'h1ff;
      @(negedge clk);
    end
    si_en = 0; in_ser = 0; wr_en = 0;
    if (!wasfull) q.push_back(w & ((1 << l) - 1));
    chk(ovf == wasfull, "R9 ovf on serial word", int'(ovf), int'(wasfull));
    check_flags("R3 flags after serial word");
  endtask

  task automatic ser_read(int setlen);
    int l, w;
    l = setlen < 4 ? 4 : (setlen > 9 ? 9 : setlen);
    ser_len = 4'(setlen);
    out_ser = 1;
    @(negedge clk);
    if (q.size() == 0) begin
      chk(so_valid == 0, "R10 no serial load when empty", int'(so_valid), 0);
      so_en = 1;
      @(negedge clk);
      so_en = 0; out_ser = 0;
      chk(udf == 1, "R10 udf on serial read", int'(udf), 1);
      check_flags("R10 flags after serial underflow");
      return;
    end
    w = q.pop_front();
    check_flags("R4 flags after serial load");
    for (int i = 0; i < l; i++) begin
      chk(so_valid == 1, "R4 so_valid", int'(so_valid), 1);
      chk(so_bit == w[i], "R4 so_bit", int'(so_bit), w[i]);
      chk(so_last == (i == l - 1), "R4 so_last", int'(so_last), int'(i == l - 1));
      so_en = 1;
      @(negedge clk);
    end
    so_en = 0; out_ser = 0;
    chk(so_valid == 0, "R4 so_valid after word", int'(so_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7321);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk({full, full_m1, afull, half, aempty, empty_p1, empty} == 7'b0000101, "R12 reset flags",
        int'({full, full_m1, afull, half, aempty, empty_p1, empty}), 7'b0000101);
    chk(rd_data == 0 && so_valid == 0 && ovf == 0 && udf == 0, "R12 reset outputs",
        int'({rd_data, so_valid, ovf, udf}), 0);

    // R1 and R6
    par_write(9'h1a5);
    par_read();

    // R11 output enable
    par_write(9'h0c3);
    par_write(9'h111);
    par_read();
    oe = 0;
    #1;
    chk(rd_data == 0, "R11 rd_data zero when oe low", int'(rd_data), 0);
    check_flags("R11 flags with oe low");
    oe = 1;
    #1;
    chk(rd_data == 9'h0c3, "R11 rd_data restored", int'(rd_data), 9'h0c3);
    par_read();

    // R5 R7 R8 fill and R9 overflow
    for (int i = 0; i < D; i++) par_write(i * 7 + 3);
    par_write(9'h155);
    ser_write(9'h0ff, 9);
    par_both(9'h0aa);
    for (int i = 0; i < D; i++) par_read();
    par_read();
    par_both(9'h123);
    par_read();

    // R3 serial in, parallel out; length limit
    ser_write(9'h1f5, 4);
    ser_write(9'h1ff, 9);
    ser_write(9'h1d6, 7);
    ser_write(9'h1ab, 2);
    for (int i = 0; i < 4; i++) par_read();

    // R4 parallel in, serial out; serial to serial; serial underflow
    par_write(9'h1b3);
    ser_read(9);
    ser_write(9'h0b7, 6);
    ser_read(6);
    ser_read(5);

    // random mix of all modes
    for (int n = 0; n < 2500; n++) begin
      int op, l;
      op = int'($urandom_range(0, 9));
      l = int'($urandom_range(4, 9));
      if (op < 3) par_write(int'($urandom_range(0, 511)));
      else if (op < 5) par_read();
      else if (op < 6) par_both(int'($urandom_range(0, 511)));
      else if (op < 8) ser_write(int'($urandom_range(0, 511)), l);
      else begin
        if (q.size() > 0) ser_len = 4'(l);
        ser_read(l);
      end
    end
    while (q.size() > 0) par_read();
    check_flags("R6 empty at end");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule